// File: doc/BRIEF.md
# Time-Slotted Serial Output Formatter

This block turns a group of parallel signal words into a single serial bit stream. A sample strobe latches seven candidate words (two in-phase/quadrature pairs, magnitude, phase or phase rate, and gain) together with the per-slot configuration. After a programmable start delay, the block sends a frame of seven time slots in a fixed order. Each slot carries one chosen word, or zeros, at one of nine widths, most significant bit first. Shifting advances only on cycles where the serial clock enable `tick` is high.

A sync output marks selected slots. The sync position is shared by all slots: one period ahead of the slot's first bit, on its first bit, or one period after its last bit. Its polarity is programmable. The sequencer is a three-state machine. `IDLE` accepts a strobe. It moves to `WAIT` when the delay is non-zero, or straight to `SHIFT` when the delay is zero. `WAIT` counts ticks down and moves to `SHIFT` on its last count. `SHIFT` walks the slots and bits. It returns to `IDLE` after the last bit of the last enabled slot, or after one period when no slot is enabled. Two output-stage registers let the sync lead the data by one period.

Top module: `slot_serializer`

## Requirements
- R1: A frame sends slots 0 to 6 in rising order. The bits of a slot are contiguous, and the next slot follows with no gap.
- R2: Slot content code (3 bits per slot, slot s in `cfg_src[3s+2:3s]`): 0 sends zeros, 1 sends I1, 2 sends Q1, 3 sends I2, 4 sends Q2, 5 sends magnitude, 6 sends phase, 7 sends gain.
- R3: Slot length code (4 bits per slot, slot s in `cfg_len[4s+3:4s]`): codes 1 to 9 give 4, 6, 8, 10, 12, 16, 20, 24 and 32 bits. Code 0 and codes 10 to 15 disable the slot. The 32-bit width sends the top 24 word bits followed by 8 zero bits.
- R4: A slot of width N sends word bits 31 down to 32-N, most significant first.
- R5: A disabled slot that has an enabled slot anywhere after it takes one period and sends 0. Disabled slots with no enabled slot after them take no time. A frame with every slot disabled takes one period and sends nothing.
- R6: Counting only the ticks at clock edges after the edge that accepts the strobe, the first frame bit appears on `sd_out` after tick D+2, where D is `cfg_delay` (0 to 4095).
- R7: `cfg_sync_mask[s]` enables the sync for slot s alone. A disabled slot never produces a sync.
- R8: Sync position code: 0 puts the sync one period before the slot's first bit, 1 on its first bit, 2 one period after its last bit, and 3 gives no sync.
- R9: `sync_out` is the active sync XOR the inversion flag latched with the last accepted strobe. After reset it is 0.
- R10: Words and configuration are sampled on the accepting edge. Input changes later in the frame do not alter it.
- R11: A strobe is ignored from the accepting edge until the sequencer finishes, which is D plus max(frame bits, 1) ticks.
- R12: `sd_out` changes only at edges with `tick` high, and is 0 whenever no frame bit is due.
- R13: During and right after reset, `sd_out` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Serial clock enable, one cycle wide |
| strobe | input | 1 | Sample strobe that starts a frame |
| in_i1 | input | 32 | Word I1 |
| in_q1 | input | 32 | Word Q1 |
| in_i2 | input | 32 | Word I2 |
| in_q2 | input | 32 | Word Q2 |
| in_mag | input | 32 | Magnitude word |
| in_phase | input | 32 | Phase or phase-rate word |
| in_gain | input | 32 | Gain word |
| cfg_src | input | 21 | Content code for each slot |
| cfg_len | input | 28 | Length code for each slot |
| cfg_sync_mask | input | 7 | Per-slot sync enable |
| cfg_sync_pos | input | 2 | Shared sync position code |
| cfg_sync_inv | input | 1 | Sync polarity inversion |
| cfg_delay | input | 12 | Start delay in ticks |
| sd_out | output | 1 | Serial data |
| sync_out | output | 1 | Sync |

## Verification
With the after-last-bit position, the sync of one slot lands in the same period as the first data bit of the next slot. The bench provokes this with back-to-back six-bit slots whose syncs are enabled on alternating slots. A second collision is a strobe that arrives while a frame is still shifting, together with a change of the input words and configuration in the same stretch. A behavioural per-tick model builds the expected data and sync timeline from the requirements. It compares both pins on every clock, so a sync that slips by a period, or a frame corrupted by a late strobe, shows up as a mismatch.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
    localparam int SLOTS    = 7;
    localparam int NSRC     = 7;
    localparam int WORD_W   = 32;
    localparam int SRC_W    = 3;
    localparam int LEN_W    = 4;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int PAD_KEEP = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } fsm_e;

    typedef enum logic [1:0] {
        SP_BEFORE = 2'd0,
        SP_FIRST  = 2'd1,
        SP_AFTER  = 2'd2,
        SP_NONE   = 2'd3
    } syncpos_e;
endpackage

// File: rtl/sfmt_len_decode.sv
module sfmt_len_decode
    import sfmt_pkg::*;
(
    input  logic [LEN_W-1:0] code,
    output logic [CNT_W-1:0] nbits,
    output logic             pad
);
    always_comb begin
        pad = 1'b0;
        case (code)
            4'd1:    nbits = CNT_W'(4);
            4'd2:    nbits = CNT_W'(6);
            4'd3:    nbits = CNT_W'(8);
            4'd4:    nbits = CNT_W'(10);
            4'd5:    nbits = CNT_W'(12);
            4'd6:    nbits = CNT_W'(16);
            4'd7:    nbits = CNT_W'(20);
            4'd8:    nbits = CNT_W'(24);
            4'd9: begin
                nbits = CNT_W'(32);
                pad   = 1'b1;
            end
            default: nbits = '0;
        endcase
    end
endmodule

// File: rtl/sfmt_word_pick.sv
module sfmt_word_pick
    import sfmt_pkg::*;
(
    input  logic [SRC_W-1:0]             src,
    input  logic [NSRC-1:0][WORD_W-1:0]  words,
    output logic [WORD_W-1:0]            word
);
    logic [SRC_W-1:0] idx;

    always_comb begin
        idx  = src - SRC_W'(1);
        word = (src == '0) ? '0 : words[idx];
    end
endmodule

// File: rtl/slot_serializer.sv
module slot_serializer
    import sfmt_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    strobe,
    input  logic [WORD_W-1:0]       in_i1,
    input  logic [WORD_W-1:0]       in_q1,
    input  logic [WORD_W-1:0]       in_i2,
    input  logic [WORD_W-1:0]       in_q2,
    input  logic [WORD_W-1:0]       in_mag,
    input  logic [WORD_W-1:0]       in_phase,
    input  logic [WORD_W-1:0]       in_gain,
    input  logic [SLOTS*SRC_W-1:0]  cfg_src,
    input  logic [SLOTS*LEN_W-1:0]  cfg_len,
    input  logic [SLOTS-1:0]        cfg_sync_mask,
    input  logic [1:0]              cfg_sync_pos,
    input  logic                    cfg_sync_inv,
    input  logic [DLY_W-1:0]        cfg_delay,
    output logic                    sd_out,
    output logic                    sync_out
);
    localparam logic [SLOT_W-1:0] ONE_S    = SLOT_W'(1);
    localparam logic [CNT_W-1:0]  ONE_B    = CNT_W'(1);
    localparam logic [DLY_W-1:0]  ONE_D    = DLY_W'(1);
    localparam logic [CNT_W-1:0]  PAD_FROM = CNT_W'(PAD_KEEP);

    fsm_e state, state_nx;

    logic [NSRC-1:0][WORD_W-1:0]  words_in, words_q;
    logic [SLOTS-1:0][SRC_W-1:0]  src_q;
    logic [SLOTS-1:0][LEN_W-1:0]  len_q;
    logic [SLOTS-1:0]             mask_q;
    syncpos_e                     pos_q;
    logic                         inv_q;
    logic [DLY_W-1:0]             cnt_q;
    logic [SLOT_W-1:0]            slot_q, slot_inc;
    logic [CNT_W-1:0]             bit_q;

    logic [SLOTS-1:0][CNT_W-1:0]  nbits;
    logic [SLOTS-1:0]             pad, en, rest_en;

    logic [WORD_W-1:0]            cur_word, shifted;
    logic [CNT_W-1:0]             cur_len;
    logic                         cur_pad, cur_en, in_slot;
    logic                         slot_done, has_next, accept;
    logic                         core_bit, core_first, core_last;

    logic                         d1_q, sd_q, f1_q, l1_q, l2_q, sync_q;

    assign words_in = {in_gain, in_phase, in_mag, in_q2, in_i2, in_q1, in_i1};

    // per-slot width decode of the latched length codes
    for (genvar g = 0; g < SLOTS; g++) begin : g_len
        sfmt_len_decode u_len (
            .code  (len_q[g]),
            .nbits (nbits[g]),
            .pad   (pad[g])
        );
        assign en[g] = |nbits[g];
    end

    // rest_en[s]: some slot at index s or later is enabled
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            acc        = acc | en[i];
            rest_en[i] = acc;
        end
    end

    sfmt_word_pick u_pick (
        .src   (src_q[slot_q]),
        .words (words_q),
        .word  (cur_word)
    );

    always_comb begin
        accept     = (state == ST_IDLE) && strobe;
        slot_inc   = slot_q + ONE_S;
        cur_len    = nbits[slot_q];
        cur_pad    = pad[slot_q];
        cur_en     = en[slot_q];
        in_slot    = (state == ST_SHIFT) && cur_en;
        shifted    = cur_word << bit_q;
        slot_done  = !cur_en || (bit_q == cur_len - ONE_B);
        has_next   = (slot_q != SLOT_W'(SLOTS - 1)) && rest_en[slot_inc];
        core_bit   = in_slot && !(cur_pad && bit_q >= PAD_FROM) && shifted[WORD_W-1];
        core_first = in_slot && (bit_q == '0) && mask_q[slot_q];
        core_last  = in_slot && (bit_q == cur_len - ONE_B) && mask_q[slot_q];
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (strobe) state_nx = (cfg_delay == '0) ? ST_SHIFT : ST_WAIT;
            ST_WAIT:  if (tick && cnt_q == ONE_D) state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && (!rest_en[slot_q] || (slot_done && !has_next)))
                          state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // capture and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            src_q   <= '0;
            len_q   <= '0;
            mask_q  <= '0;
            pos_q   <= SP_NONE;
            inv_q   <= 1'b0;
            cnt_q   <= '0;
            slot_q  <= '0;
            bit_q   <= '0;
        end else if (accept) begin
            words_q <= words_in;
            src_q   <= cfg_src;
            len_q   <= cfg_len;
            mask_q  <= cfg_sync_mask;
            pos_q   <= syncpos_e'(cfg_sync_pos);
            inv_q   <= cfg_sync_inv;
            cnt_q   <= cfg_delay;
            slot_q  <= '0;
            bit_q   <= '0;
        end else if (tick) begin
            if (state == ST_WAIT) begin
                cnt_q <= cnt_q - ONE_D;
            end else if (state == ST_SHIFT) begin
                if (slot_done) begin
                    slot_q <= slot_inc;
                    bit_q  <= '0;
                end else begin
                    bit_q  <= bit_q + ONE_B;
                end
            end
        end
    end

    // output stage: data runs one period behind the sequencer so the sync can lead it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_q   <= 1'b0;
            sd_q   <= 1'b0;
            f1_q   <= 1'b0;
            l1_q   <= 1'b0;
            l2_q   <= 1'b0;
            sync_q <= 1'b0;
        end else if (tick) begin
            d1_q <= core_bit;
            sd_q <= d1_q;
            f1_q <= core_first;
            l1_q <= core_last;
            l2_q <= l1_q;
            unique case (pos_q)
                SP_BEFORE: sync_q <= core_first;
                SP_FIRST:  sync_q <= f1_q;
                SP_AFTER:  sync_q <= l2_q;
                default:   sync_q <= 1'b0;
            endcase
        end
    end

    assign sd_out   = sd_q;
    assign sync_out = sync_q ^ inv_q;

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(words_q) && $stable(len_q) && $stable(src_q)); // R11
    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && !tick |=> $stable(bit_q) && $stable(slot_q) && $stable(cnt_q)); // R12
    AST_SD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sd_out)); // R12
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) && tick && slot_done && has_next
        |=> (state == ST_SHIFT) && (slot_q == $past(slot_q) + ONE_S) && (bit_q == '0)); // R1
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) && cur_en |-> bit_q < cur_len); // R3
    AST_DELAY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) && tick && (cnt_q > ONE_D)
        |=> (state == ST_WAIT) && (cnt_q == $past(cnt_q) - ONE_D)); // R6
endmodule

// File: tb/slot_serializer_tb.sv
`timescale 1ns/1ps
module slot_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        strobe = 1'b0;
    logic [31:0] in_i1 = '0, in_q1 = '0, in_i2 = '0, in_q2 = '0;
    logic [31:0] in_mag = '0, in_phase = '0, in_gain = '0;
    logic [20:0] cfg_src = '0;
    logic [27:0] cfg_len = '0;
    logic [6:0]  cfg_sync_mask = '0;
    logic [1:0]  cfg_sync_pos = 2'd3;
    logic        cfg_sync_inv = 1'b0;
    logic [11:0] cfg_delay = '0;
    logic        sd_out, sync_out;

    always #2 clk = ~clk;

    slot_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(strobe),
        .in_i1(in_i1), .in_q1(in_q1), .in_i2(in_i2), .in_q2(in_q2),
        .in_mag(in_mag), .in_phase(in_phase), .in_gain(in_gain),
        .cfg_src(cfg_src), .cfg_len(cfg_len), .cfg_sync_mask(cfg_sync_mask),
        .cfg_sync_pos(cfg_sync_pos), .cfg_sync_inv(cfg_sync_inv),
        .cfg_delay(cfg_delay), .sd_out(sd_out), .sync_out(sync_out)
    );

    int    total = 0, bad = 0, cyc = 0;
    int    tick_cnt = 0, busy_until = 0;
    int    en_period = 1, en_phase = 0;
    bit    inv_m = 1'b0;
    bit    exp_sd [int];
    bit    exp_sy [int];
    string req = "R13";

    function automatic int width_of(input logic [3:0] c);
        case (c)
            4'd1: return 4;   4'd2: return 6;   4'd3: return 8;
            4'd4: return 10;  4'd5: return 12;  4'd6: return 16;
            4'd7: return 20;  4'd8: return 24;  4'd9: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] word_of(input logic [2:0] c);
        case (c)
            3'd1: return in_i1;   3'd2: return in_q1;  3'd3: return in_i2;
            3'd4: return in_q2;   3'd5: return in_mag; 3'd6: return in_phase;
            3'd7: return in_gain; default: return '0;
        endcase
    endfunction

    task automatic set_slot(input int s, input logic [2:0] src, input logic [3:0] len);
        cfg_src[s*3 +: 3] = src;
        cfg_len[s*4 +: 4] = len;
    endtask

    // behavioural timeline of one accepted frame
    task automatic build_frame();
        int t0, d, j, j0, w;
        logic [31:0] word;
        bit later;
        t0 = tick_cnt;
        d  = int'(cfg_delay);
        j  = 0;
        for (int s = 0; s < 7; s++) begin
            w = width_of(cfg_len[s*4 +: 4]);
            if (w > 0) begin
                word = word_of(cfg_src[s*3 +: 3]);
                j0 = j;
                for (int b = 0; b < w; b++) begin
                    exp_sd[t0 + d + 2 + j] = (w == 32 && b >= 24) ? 1'b0 : word[31 - b];
                    j++;
                end
                if (cfg_sync_mask[s]) begin
                    case (cfg_sync_pos)
                        2'd0: exp_sy[t0 + d + 1 + j0] = 1'b1;
                        2'd1: exp_sy[t0 + d + 2 + j0] = 1'b1;
                        2'd2: exp_sy[t0 + d + 2 + j]  = 1'b1;
                        default: ;
                    endcase
                end
            end else begin
                later = 1'b0;
                for (int s2 = s + 1; s2 < 7; s2++)
                    if (width_of(cfg_len[s2*4 +: 4]) > 0) later = 1'b1;
                if (later) begin
                    exp_sd[t0 + d + 2 + j] = 1'b0;
                    j++;
                end
            end
        end
        busy_until = t0 + d + ((j == 0) ? 1 : j);
        inv_m = cfg_sync_inv;
    endtask

    always @(posedge clk) begin
        bit idle;
        if (rst_n) begin
            idle = (tick_cnt >= busy_until);
            if (tick) tick_cnt++;
            if (strobe && idle) build_frame();
        end
    end

    always @(negedge clk) begin
        tick = (en_phase == 0);
        en_phase = (en_phase + 1 >= en_period) ? 0 : en_phase + 1;
    end

    task automatic check(input bit ok, input string what, input bit got, input bit exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0b exp=%0b tick=%0d", req, what, got, exp, tick_cnt);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        bit e_sd, e_sy;
        if (rst_n) begin
            e_sd = exp_sd.exists(tick_cnt) ? exp_sd[tick_cnt] : 1'b0;
            e_sy = (exp_sy.exists(tick_cnt) ? exp_sy[tick_cnt] : 1'b0) ^ inv_m;
            check(sd_out === e_sd, "sd_out", sd_out, e_sd);
            check(sync_out === e_sy, "sync_out", sync_out, e_sy);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired in phase %s", req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic strobe_pulse();
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (tick_cnt < busy_until + 4) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R13: reset state
        repeat (4) begin
            @(negedge clk);
            check(sd_out === 1'b0, "sd_out in reset", sd_out, 1'b0);
            check(sync_out === 1'b0, "sync_out in reset", sync_out, 1'b0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R4 R8: every source, widths 4..20, sync on first bit
        req = "R1/R2/R4/R8";
        en_period = 1;
        in_i1 = 32'hA5C3_0F1E; in_q1 = 32'h5A3C_F0E1; in_i2 = 32'hDEAD_BEEF;
        in_q2 = 32'h1234_5678; in_mag = 32'h8001_7FFE; in_phase = 32'hC0FF_EE00;
        in_gain = 32'h96E1_3B4D;
        for (int s = 0; s < 7; s++) set_slot(s, 3'(s + 1), 4'(s + 1));
        cfg_sync_mask = 7'h7F; cfg_sync_pos = 2'd1; cfg_sync_inv = 1'b0; cfg_delay = 12'd0;
        strobe_pulse();
        wait_done();

        // R3 R5 R7 R9: 32-bit pad, disabled gaps, trailing disabled, sync ahead, inverted
        req = "R3/R5/R7/R9";
        en_period = 3;
        set_slot(0, 3'd5, 4'd9);  set_slot(1, 3'd1, 4'd0);  set_slot(2, 3'd0, 4'd8);
        set_slot(3, 3'd2, 4'd12); set_slot(4, 3'd7, 4'd1);  set_slot(5, 3'd3, 4'd0);
        set_slot(6, 3'd4, 4'd15);
        in_mag = 32'hFFFF_FFFF;
        cfg_sync_mask = 7'h7F; cfg_sync_pos = 2'd0; cfg_sync_inv = 1'b1; cfg_delay = 12'd5;
        strobe_pulse();
        wait_done();

        // R6 R7 R8 R10 R11: sync after last bit meets next slot's first bit,
        // inputs changed and strobes sent mid-frame
        req = "R6/R7/R8/R10/R11";
        en_period = 2;
        for (int s = 0; s < 7; s++) set_slot(s, 3'(7 - s), 4'd2);
        cfg_sync_mask = 7'b0101010; cfg_sync_pos = 2'd2; cfg_sync_inv = 1'b0; cfg_delay = 12'd3;
        strobe_pulse();
        repeat (9) @(negedge clk);
        in_gain = 32'h0000_0000; in_q2 = 32'hFFFF_FFFF;
        for (int s = 0; s < 7; s++) set_slot(s, 3'd1, 4'd9);
        cfg_sync_pos = 2'd0; cfg_sync_inv = 1'b1; cfg_delay = 12'd0;
        strobe_pulse();
        repeat (20) @(negedge clk);
        strobe_pulse();
        wait_done();

        // R5 R11: all slots disabled, second strobe right behind the first
        req = "R5/R11";
        en_period = 1;
        for (int s = 0; s < 7; s++) set_slot(s, 3'd1, 4'd0);
        cfg_sync_pos = 2'd3; cfg_sync_inv = 1'b0; cfg_delay = 12'd2;
        strobe_pulse();
        strobe_pulse();
        wait_done();

        // R6 R12: longest delay, one slot at the end behind six one-period gaps
        req = "R6/R12";
        set_slot(6, 3'd6, 4'd3);
        cfg_sync_mask = 7'h40; cfg_sync_pos = 2'd0; cfg_delay = 12'd4095;
        strobe_pulse();
        wait_done();

        // R12: sparse enable, zero delay, inverted sync on first bit
        req = "R12";
        en_period = 5;
        set_slot(0, 3'd4, 4'd1); set_slot(6, 3'd0, 4'd0); set_slot(3, 3'd6, 4'd4);
        cfg_sync_mask = 7'h09; cfg_sync_pos = 2'd1; cfg_sync_inv = 1'b1; cfg_delay = 12'd0;
        strobe_pulse();
        wait_done();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule